// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit counter that runs freely from reset, paced by a prescaler, with a bank of event channels built around it. Some channels record the count when an input pin changes level. Other channels raise a flag when the count reaches a programmed value. Software uses a small word-wide register bus to pick the prescale rate, load compare values, read captured values, and handle a flag and an interrupt-enable bit for every function, including counter overflow.

The counter cannot be loaded, cleared or halted by any bus access. It wraps from full scale back to zero and raises the overflow flag as it does so. The prescale rate can be set only during a short window after reset, so a runaway program cannot change the time base later.

In the default build there are three capture channels (0 to 2), four compare channels (3 to 6) and one channel (7) that can act as either. Flag and enable bit 8 belongs to overflow. The bus decodes these addresses: 0x00 count (read only), 0x01 prescale select, 0x02 mode, 0x03 edge select, 0x04 flags, 0x05 interrupt enables, and 0x08+n for the data register of channel n.

Top module: `tmr_capcmp`

## Requirements
- R1: Bits [1:0] at address 0x01 choose how often the counter steps. Code 0 steps it every clock, code 1 every 4 clocks, code 2 every 8 clocks and code 3 every 16 clocks. The field resets to code 0.
- R2: The count at address 0x00 reads 0x0000 in the first cycle after reset is released. It then rises by exactly one at each prescaler step.
- R3: After 0xFFFF the count steps to 0x0000. On that same step it sets flag bit 8 at address 0x04, and it keeps counting.
- R4: A bus write to address 0x00 does not change the count or its stepping.
- R5: A write to the prescale field takes effect only if it lands on one of the first 64 clock edges after reset is released (edges 1 to 64). A later write is ignored, and both the read-back value and the stepping rate stay as they were.
- R6: Capture channels 0 to 2 sample pins 0 to 2 through a two-flop synchronizer. Bit n at address 0x03 picks the edge: 0 for rising, 1 for falling. On the selected edge, the data register at 0x08+n takes the count held during the clock after the second sampling edge, and flag bit n is set. The other edge does nothing.
- R7: Compare channels 3 to 6 keep a register at 0x08+n, which resets to 0xFFFF. Flag bit n is set on the clock edge where the count steps to a value equal to that register.
- R8: Channel 7 is a capture channel on pin 3 while bit 0 at address 0x02 is 0, and a compare channel while that bit is 1. Its register at 0x0F returns the captured value in the first mode and the compare value in the second. It reports through flag bit 7.
- R9: Flags at address 0x04 stay set until software writes 1 to the bit. Writing 0 leaves a flag as it is. All flags reset to 0.
- R10: irq[n] is high exactly when flag n and enable bit n at address 0x05 are both set. A flag is still set while its enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_pin | input | 4 | Capture pins: 0 to 2 for channels 0 to 2, 3 for channel 7 |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 5 | Register address for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 9 | Request lines: bits 0 to 7 for the channels, bit 8 for overflow |

## Verification
The assertions rely on three things about the inputs. Reset must be held for at least one edge. The bus must carry known values whenever the strobe is high. The compare check needs no restriction on register writes in the matching cycle, because it compares the count with the register value from before that edge. The prescale-lock property counts cycles since reset in its own counter, so it assumes that reset is the only thing that reopens the window. The bench changes every input on the falling clock edge. It holds each capture pin level for at least five clocks, so the synchronizer always sees a clean level before the next change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      PS_DIV1  = 2'd0,
      PS_DIV4  = 2'd1,
      PS_DIV8  = 2'd2,
      PS_DIV16 = 2'd3
   } presc_e;

   localparam int unsigned REG_COUNT     = 0;
   localparam int unsigned REG_PRESC     = 1;
   localparam int unsigned REG_MODE      = 2;
   localparam int unsigned REG_EDGE      = 3;
   localparam int unsigned REG_FLAGS     = 4;
   localparam int unsigned REG_IEN       = 5;
   localparam int unsigned REG_CHAN_BASE = 8;

   // Low divider bits that must all be ones for a step to happen.
   function automatic logic [3:0] presc_mask(presc_e sel);
      case (sel)
         PS_DIV1:  return 4'b0000;
         PS_DIV4:  return 4'b0011;
         PS_DIV8:  return 4'b0111;
         default:  return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int unsigned LOCK_CYC = 64
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr,
   input  logic [1:0] wdata,
   output logic [1:0] presc_q,
   output logic       tick
);

   localparam int unsigned LW = (LOCK_CYC > 0) ? $clog2(LOCK_CYC + 1) : 1;

   logic       open_w;
   logic [3:0] div_q;

   // LOCK_CYC == 0 leaves the select writable at all times.
   if (LOCK_CYC == 0) begin : g_open
      assign open_w = 1'b1;
   end else begin : g_lock
      logic [LW-1:0] lock_q;
      always_ff @(posedge clk) begin
         if (rst)
            lock_q <= '0;
         else if (lock_q != LW'(LOCK_CYC))
            lock_q <= lock_q + 1'b1;
      end
      assign open_w = (lock_q != LW'(LOCK_CYC));
   end

   always_ff @(posedge clk) begin
      if (rst)
         presc_q <= 2'd0;
      else if (wr && open_w)
         presc_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   assign tick = &(div_q | ~presc_mask(presc_e'(presc_q)));

endmodule

// File: rtl/tmr_capture_ch.sv
module tmr_capture_ch #(
   parameter int unsigned W        = 16,
   parameter int unsigned SYNC_STG = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         pin,
   input  logic         fall_sel,
   input  logic         enable,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] latch_q,
   output logic         hit
);

   logic [SYNC_STG-1:0] sync_q;
   logic                prev_q;
   logic                lvl;
   logic                edge_w;

   always_ff @(posedge clk) begin
      if (rst)
         sync_q <= '0;
      else
         sync_q <= {sync_q[SYNC_STG-2:0], pin};
   end

   assign lvl = sync_q[SYNC_STG-1];

   always_ff @(posedge clk) begin
      if (rst)
         prev_q <= 1'b0;
      else
         prev_q <= lvl;
   end

   assign edge_w = fall_sel ? (prev_q & ~lvl) : (~prev_q & lvl);
   assign hit    = enable & edge_w;

   always_ff @(posedge clk) begin
      if (rst)
         latch_q <= '0;
      else if (hit)
         latch_q <= cnt;
   end

endmodule

// File: rtl/tmr_compare_ch.sv
module tmr_compare_ch #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         tick,
   input  logic [W-1:0] cnt_nxt,
   input  logic         enable,
   output logic [W-1:0] cmp_q,
   output logic         hit
);

   always_ff @(posedge clk) begin
      if (rst)
         cmp_q <= '1;
      else if (wr)
         cmp_q <= wdata;
   end

   // Match is taken on the step that brings the count onto the value.
   assign hit = enable & tick & (cnt_nxt == cmp_q);

endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned N_CAP    = 3,
   parameter int unsigned N_CMP    = 4,
   parameter int unsigned LOCK_CYC = 64,
   parameter int unsigned SYNC_STG = 2,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [N_CAP:0]           cap_pin,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic [N_CAP+N_CMP+1:0]   irq
);

   localparam int unsigned N_CH  = N_CAP + N_CMP + 1;
   localparam int unsigned SW    = N_CAP + N_CMP;
   localparam int unsigned OVF   = N_CH;
   localparam int unsigned FLG_W = N_CH + 1;
   localparam int unsigned N_PIN = N_CAP + 1;

   // Elaboration checks on the parameter set
   if (DATA_W < CNT_W) begin : g_bad_data_w
      $error("tmr_capcmp: DATA_W must hold the counter");
   end
   if (DATA_W < FLG_W) begin : g_bad_flag_w
      $error("tmr_capcmp: DATA_W must hold every flag");
   end
   if (REG_CHAN_BASE + N_CH > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("tmr_capcmp: ADDR_W too small for channel registers");
   end
   if (SYNC_STG < 2) begin : g_bad_sync
      $error("tmr_capcmp: SYNC_STG must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_capcmp: CNT_W must be at least 2");
   end

   logic              tick;
   logic [1:0]        presc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              wrap;
   logic              mode_q;
   logic [N_PIN-1:0]  edge_q;
   logic [FLG_W-1:0]  ien_q;
   logic [FLG_W-1:0]  flags_q;
   logic [FLG_W-1:0]  clr_v;
   logic [N_CH-1:0]   wr_chan;
   logic [N_CAP-1:0]  cap_hit;
   logic [N_CMP-1:0]  cmp_hit;
   logic              sw_cap_hit;
   logic              sw_cmp_hit;
   logic [CNT_W-1:0]  sw_cap_val;
   logic [CNT_W-1:0]  sw_cmp_val;
   logic [CNT_W-1:0]  cap_val [N_CAP];
   logic [CNT_W-1:0]  cmp_val [N_CMP];
   logic [N_CMP*CNT_W-1:0] cmp_flat;

   logic wr_presc, wr_mode, wr_edge, wr_flags, wr_ien;

   assign wr_presc = bus_wr && (bus_addr == ADDR_W'(REG_PRESC));
   assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(REG_MODE));
   assign wr_edge  = bus_wr && (bus_addr == ADDR_W'(REG_EDGE));
   assign wr_flags = bus_wr && (bus_addr == ADDR_W'(REG_FLAGS));
   assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(REG_IEN));

   always_comb begin
      for (int k = 0; k < N_CH; k++)
         wr_chan[k] = bus_wr && (bus_addr == ADDR_W'(REG_CHAN_BASE + k));
   end

   // Time base
   tmr_prescale #(.LOCK_CYC(LOCK_CYC)) u_presc (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_presc),
      .wdata   (bus_wdata[1:0]),
      .presc_q (presc_q),
      .tick    (tick)
   );

   assign cnt_nxt = cnt_q + 1'b1;
   assign wrap    = tick && (&cnt_q);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_nxt;
   end

   // Configuration registers
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= 1'b0;
         edge_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= bus_wdata[0];
         if (wr_edge) edge_q <= bus_wdata[N_PIN-1:0];
         if (wr_ien)  ien_q  <= bus_wdata[FLG_W-1:0];
      end
   end

   // Dedicated capture channels
   for (genvar i = 0; i < N_CAP; i++) begin : g_cap
      tmr_capture_ch #(.W(CNT_W), .SYNC_STG(SYNC_STG)) u_cap (
         .clk      (clk),
         .rst      (rst),
         .pin      (cap_pin[i]),
         .fall_sel (edge_q[i]),
         .enable   (1'b1),
         .cnt      (cnt_q),
         .latch_q  (cap_val[i]),
         .hit      (cap_hit[i])
      );
   end

   // Dedicated compare channels
   for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
      tmr_compare_ch #(.W(CNT_W)) u_cmp (
         .clk     (clk),
         .rst     (rst),
         .wr      (wr_chan[N_CAP+j]),
         .wdata   (bus_wdata[CNT_W-1:0]),
         .tick    (tick),
         .cnt_nxt (cnt_nxt),
         .enable  (1'b1),
         .cmp_q   (cmp_val[j]),
         .hit     (cmp_hit[j])
      );
      assign cmp_flat[j*CNT_W +: CNT_W] = cmp_val[j];
   end

   // Switchable channel: both halves exist, mode picks the live one
   tmr_capture_ch #(.W(CNT_W), .SYNC_STG(SYNC_STG)) u_sw_cap (
      .clk      (clk),
      .rst      (rst),
      .pin      (cap_pin[N_CAP]),
      .fall_sel (edge_q[N_CAP]),
      .enable   (~mode_q),
      .cnt      (cnt_q),
      .latch_q  (sw_cap_val),
      .hit      (sw_cap_hit)
   );

   tmr_compare_ch #(.W(CNT_W)) u_sw_cmp (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_chan[SW] & mode_q),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .tick    (tick),
      .cnt_nxt (cnt_nxt),
      .enable  (mode_q),
      .cmp_q   (sw_cmp_val),
      .hit     (sw_cmp_hit)
   );

   // Flags: set has priority over write-one-to-clear
   assign clr_v = wr_flags ? bus_wdata[FLG_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (rst)
         flags_q <= '0;
      else
         flags_q <= (flags_q & ~clr_v) | {wrap, sw_cap_hit | sw_cmp_hit, cmp_hit, cap_hit};
   end

   assign irq = flags_q & ien_q;

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_COUNT): bus_rdata = DATA_W'(cnt_q);
         ADDR_W'(REG_PRESC): bus_rdata = DATA_W'(presc_q);
         ADDR_W'(REG_MODE):  bus_rdata = DATA_W'(mode_q);
         ADDR_W'(REG_EDGE):  bus_rdata = DATA_W'(edge_q);
         ADDR_W'(REG_FLAGS): bus_rdata = DATA_W'(flags_q);
         ADDR_W'(REG_IEN):   bus_rdata = DATA_W'(ien_q);
         default: begin
            for (int k = 0; k < N_CAP; k++)
               if (bus_addr == ADDR_W'(REG_CHAN_BASE + k))
                  bus_rdata = DATA_W'(cap_val[k]);
            for (int k = 0; k < N_CMP; k++)
               if (bus_addr == ADDR_W'(REG_CHAN_BASE + N_CAP + k))
                  bus_rdata = DATA_W'(cmp_val[k]);
            if (bus_addr == ADDR_W'(REG_CHAN_BASE + SW))
               bus_rdata = DATA_W'(mode_q ? sw_cmp_val : sw_cap_val);
         end
      endcase
   end

endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned N_CAP    = 3,
   parameter int unsigned N_CMP    = 4,
   parameter int unsigned LOCK_CYC = 64,
   parameter int unsigned ADDR_W   = 5
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    tick,
   input logic [CNT_W-1:0]        cnt,
   input logic [N_CAP+N_CMP+1:0]  flags,
   input logic [1:0]              presc,
   input logic                    bus_wr,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [N_CMP*CNT_W-1:0]  cmp_flat
);

   localparam int unsigned OVF = N_CAP + N_CMP + 1;

   // R3: full scale steps to zero and raises overflow
   a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
      (tick && (&cnt)) |=> (cnt == '0 && flags[OVF]));

   // R2: every step adds exactly one
   a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R4: nothing but a step moves the count
   a_r4_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));

   // R9: flags stay set without a flag-register write
   a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && bus_addr == ADDR_W'(REG_FLAGS)) |=> ((flags & $past(flags)) == $past(flags)));

   // R7: a compare flag rises only with the count on its register value
   for (genvar j = 0; j < N_CMP; j++) begin : g_cmp_chk
      a_r7_match_value: assert property (@(posedge clk) disable iff (rst)
         $rose(flags[N_CAP+j]) |-> (cnt == $past(cmp_flat[j*CNT_W +: CNT_W])));
   end

   // R5: after the window the prescale select never moves
   if (LOCK_CYC > 0) begin : g_lock_chk
      localparam int unsigned LW = $clog2(LOCK_CYC + 1);
      logic [LW-1:0] since_q;
      always_ff @(posedge clk) begin
         if (rst)
            since_q <= '0;
         else if (since_q != LW'(LOCK_CYC))
            since_q <= since_q + 1'b1;
      end
      a_r5_presc_locked: assert property (@(posedge clk) disable iff (rst)
         (since_q == LW'(LOCK_CYC)) |=> $stable(presc));
   end

endmodule

bind tmr_capcmp tmr_capcmp_chk #(
   .CNT_W    (CNT_W),
   .N_CAP    (N_CAP),
   .N_CMP    (N_CMP),
   .LOCK_CYC (LOCK_CYC),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick),
   .cnt      (cnt_q),
   .flags    (flags_q),
   .presc    (presc_q),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .cmp_flat (cmp_flat)
);

// File: tb/tb_tmr_capcmp.sv
module tb_tmr_capcmp;

   localparam int A_COUNT = 0, A_PRESC = 1, A_MODE = 2, A_EDGE = 3,
                  A_FLAGS = 4, A_IEN = 5, A_CH = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  cap_pin = '0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [8:0]  irq;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_capcmp dut (
      .clk       (clk),
      .rst       (rst),
      .cap_pin   (cap_pin),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int addr, output logic [15:0] data);
      bus_addr = 5'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic wr(input int addr, input logic [15:0] data);
      bus_addr  = 5'(addr);
      bus_wdata = data;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cap_pin = '0;
      bus_wr = 1'b0;
      step(4);
      rst = 1'b0;
   endtask

   task automatic wait_irq(input int b, input int maxc, output logic got, output logic [15:0] cv);
      got = 1'b0;
      cv = '0;
      for (int i = 0; i < maxc; i++) begin
         rd(A_COUNT, cv);
         if (irq[b]) begin
            got = 1'b1;
            return;
         end
         step(1);
      end
   endtask

   task automatic t_reset_state();
      logic [15:0] v;
      do_reset();
      rd(A_COUNT, v);      check("R2 count at reset", v, 16'h0000);
      rd(A_PRESC, v);      check("R1 prescale reset", v, 16'h0000);
      rd(A_CH + 3, v);     check("R7 compare reset", v, 16'hFFFF);
      rd(A_FLAGS, v);      check("R9 flags reset", v, 16'h0000);
      check("R10 irq reset", irq, 9'h000);
      step(10);
      rd(A_COUNT, v);      check("R2 count after 10", v, 16'd10);
   endtask

   task automatic t_presc_rate(input logic [1:0] code, input int div);
      logic [15:0] c0, c1;
      do_reset();
      wr(A_PRESC, 16'(code));
      rd(A_COUNT, c0);
      step(div * 10);
      rd(A_COUNT, c1);
      check("R1 prescale rate", 32'(c1 - c0), 32'd10);
   endtask

   task automatic t_presc_lock();
      logic [15:0] v, c0, c1;
      do_reset();
      wr(A_PRESC, 16'd2);
      step(100);
      wr(A_PRESC, 16'd0);
      rd(A_PRESC, v);      check("R5 late write ignored", v, 16'd2);
      rd(A_COUNT, c0);
      step(40);
      rd(A_COUNT, c1);     check("R5 rate unchanged", 32'(c1 - c0), 32'd5);
      do_reset();
      step(63);
      wr(A_PRESC, 16'd3);
      rd(A_PRESC, v);      check("R5 write on edge 64 taken", v, 16'd3);
      do_reset();
      step(64);
      wr(A_PRESC, 16'd1);
      rd(A_PRESC, v);      check("R5 write on edge 65 ignored", v, 16'd0);
   endtask

   task automatic t_count_nowrite();
      logic [15:0] c0, c1;
      do_reset();
      step(5);
      rd(A_COUNT, c0);
      wr(A_COUNT, 16'h1234);
      rd(A_COUNT, c1);     check("R4 write ignored", c1, 16'(c0 + 1));
   endtask

   task automatic t_compare();
      logic [15:0] c, cmp, v;
      logic got;
      rd(A_COUNT, c);
      cmp = c + 16'd30;
      wr(A_CH + 3, cmp);
      rd(A_CH + 3, v);     check("R7 compare readback", v, cmp);
      wait_irq(3, 100, got, v);
      check("R7 match flagged", 32'(got), 32'd1);
      check("R7 count at match", v, cmp);
   endtask

   task automatic t_ien_masked();
      logic [15:0] c, v;
      rd(A_COUNT, c);
      wr(A_CH + 4, c + 16'd5);
      step(10);
      check("R10 masked irq low", 32'(irq[4]), 32'd0);
      rd(A_FLAGS, v);      check("R10 flag still set", 32'(v[4]), 32'd1);
   endtask

   task automatic t_w1c();
      logic [15:0] v;
      wr(A_FLAGS, 16'h0000);
      rd(A_FLAGS, v);      check("R9 zero write keeps", 32'(v & 16'h0018), 32'h18);
      wr(A_FLAGS, 16'h0008);
      rd(A_FLAGS, v);      check("R9 one write clears", 32'(v & 16'h0018), 32'h10);
      check("R9 irq follows clear", 32'(irq[3]), 32'd0);
   endtask

   task automatic t_capture();
      logic [15:0] c, v;
      wr(A_EDGE, 16'h0000);
      cap_pin[0] = 1'b1;
      step(2);
      rd(A_COUNT, c);
      step(3);
      rd(A_CH + 0, v);     check("R6 rising capture value", v, c);
      check("R6 rising capture flag", 32'(irq[0]), 32'd1);
      wr(A_FLAGS, 16'h0001);
      cap_pin[0] = 1'b0;
      step(5);
      rd(A_FLAGS, v);      check("R6 falling ignored flag", 32'(v[0]), 32'd0);
      rd(A_CH + 0, v);     check("R6 falling ignored value", v, c);
      wr(A_EDGE, 16'h0002);
      cap_pin[1] = 1'b1;
      step(5);
      rd(A_FLAGS, v);      check("R6 rising ignored on falling select", 32'(v[1]), 32'd0);
      cap_pin[1] = 1'b0;
      step(2);
      rd(A_COUNT, c);
      step(3);
      rd(A_CH + 1, v);     check("R6 falling capture value", v, c);
      rd(A_FLAGS, v);      check("R6 falling capture flag", 32'(v[1]), 32'd1);
   endtask

   task automatic t_switchable();
      logic [15:0] c, v, cmp;
      logic got;
      cap_pin[3] = 1'b1;
      step(2);
      rd(A_COUNT, c);
      step(3);
      rd(A_CH + 7, v);     check("R8 capture mode value", v, c);
      check("R8 capture mode flag", 32'(irq[7]), 32'd1);
      wr(A_FLAGS, 16'h0080);
      wr(A_MODE, 16'h0001);
      rd(A_COUNT, c);
      cmp = c + 16'd20;
      wr(A_CH + 7, cmp);
      rd(A_CH + 7, v);     check("R8 compare mode readback", v, cmp);
      cap_pin[3] = 1'b0;
      wait_irq(7, 60, got, v);
      check("R8 compare mode flagged", 32'(got), 32'd1);
      check("R8 compare mode count", v, cmp);
   endtask

   task automatic t_overflow();
      logic [15:0] v;
      logic got;
      wr(A_FLAGS, 16'h01FF);
      wait_irq(8, 70000, got, v);
      check("R3 overflow flagged", 32'(got), 32'd1);
      check("R3 count after wrap", v, 16'h0000);
      rd(A_FLAGS, v);      check("R3 overflow flag bit", 32'(v[8]), 32'd1);
      step(3);
      rd(A_COUNT, v);      check("R3 keeps counting", v, 16'd3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_presc_rate(2'd0, 1);
      t_presc_rate(2'd1, 4);
      t_presc_rate(2'd2, 8);
      t_presc_rate(2'd3, 16);
      t_presc_lock();
      t_count_nowrite();
      wr(A_IEN, 16'h01EF);
      t_compare();
      t_ien_masked();
      t_w1c();
      t_capture();
      t_switchable();
      t_overflow();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule